// File: doc/BRIEF.md
# Bang-Bang Loop Filter and Oscillator Code Generator

This block sits between a bang-bang phase/frequency detector and a digitally controlled oscillator. It keeps an 18-bit oscillator control code up to date. Each cycle the detector reports one of two polarities: early (the code must rise, which slows the oscillator) or late (the code must fall, which speeds it up). The block moves the code by a search step. Each time the polarity flips, the block halves the step and reloads the code with an averaged baseline. This makes the loop a binary search that settles without an analog filter capacitor.

After a run of polarity flips at the smallest step, the block raises a lock flag. While the lock flag is high, a spread request freezes the baseline as the center code. The code then follows the add/subtract flag and step word of an external modulation controller, so the oscillator frequency sweeps around that center. Dropping the request returns the code to the center in one cycle, and tracking then resumes.

Top module: `ssc_code_ctrl`

## Requirements
- R1: While `rst_n` is low, `code_o` and `base_o` are 131072 (2^17) and `locked_o` is 0. The internal search step resets to 16384, and no previous polarity is remembered.
- R2: In tracking mode, if `early_i`=1 and `late_i`=0 and this is not a polarity reversal, `code_o` rises by the current search step at the next clock edge. The result saturates at 262143.
- R3: In tracking mode, if `late_i`=1 and `early_i`=0 and this is not a polarity reversal, `code_o` falls by the current search step at the next clock edge. The result saturates at 0.
- R4: A reversal is a valid decision whose polarity differs from the last valid decision. On a reversal, `code_o` and `base_o` both become (C_prev + C_now) >> 1. C_now is the code before the reversal. C_prev is the code before the previous reversal, or 131072 if there has been no earlier reversal.
- R5: On each reversal the search step halves, but it never goes below 1. The new step applies from the next decision onward.
- R6: In tracking mode, if `early_i` and `late_i` are equal (both 0 or both 1), the code, the baseline and the remembered polarity do not change.
- R7: A reversal taken while the step is already 1 increments a run count, which saturates at 4. `locked_o` rises on the edge where that count reaches 4 and stays high until reset.
- R8: If `spread_req_i`=1 while `locked_o`=1, the next edge loads `code_o` with `base_o` and enters spread mode. After that, each edge adds `mod_step_i` (`mod_add_i`=1) or subtracts it (`mod_add_i`=0), saturating at 0 and 262143. In spread mode `early_i` and `late_i` have no effect and `base_o` holds its value.
- R9: If `spread_req_i`=1 while `locked_o`=0, the request is ignored and tracking continues as in R2 to R6.
- R10: In spread mode, if `spread_req_i`=0, the next edge returns `code_o` to `base_o` and leaves spread mode. Tracking resumes with the search step and polarity history it had before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| early_i | input | 1 | Detector decision: raise the code (slow the oscillator) |
| late_i | input | 1 | Detector decision: lower the code (speed up the oscillator) |
| spread_req_i | input | 1 | Request for spread-spectrum operation |
| mod_add_i | input | 1 | Modulation direction: 1 adds, 0 subtracts |
| mod_step_i | input | 16 | Modulation step per cycle in spread mode |
| code_o | output | 18 | Oscillator control code |
| base_o | output | 18 | Averaged baseline; the center code while spreading |
| locked_o | output | 1 | Lock flag; gates entry into spread mode |

## Verification
Every output is a register, so the inputs sampled at one rising edge show up on `code_o`, `base_o` and `locked_o` right after that edge, one cycle after they were applied. This holds for reversals, spread entry and spread exit alike. The bench drives its inputs on the falling edge and advances its reference model on the rising edge from those same inputs. It compares all three outputs at the next falling edge, so each result is checked in the cycle it is due. The detector decisions in the closed-loop phase come from the code observed on the previous falling edge, which keeps the one-cycle loop delay visible to the model.

// File: rtl/ssc_code_pkg.sv
package ssc_code_pkg;

    // Last valid detector polarity remembered by the search controller.
    typedef enum logic [1:0] {
        POL_NONE  = 2'd0,
        POL_EARLY = 2'd1,
        POL_LATE  = 2'd2
    } pol_e;

endpackage

// File: rtl/ssc_sat_adj.sv
// Combinational saturating add/subtract of a step onto a code word.
module ssc_sat_adj #(
    parameter int CODE_W = 18,
    parameter int STEP_W = 16
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              up_i,
    output logic [CODE_W-1:0] res_o
);
    localparam int SUM_W = CODE_W + 1;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [SUM_W-1:0] wide_code;
    logic [SUM_W-1:0] wide_step;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] diff;

    assign wide_code = {1'b0, code_i};
    assign wide_step = {{(SUM_W-STEP_W){1'b0}}, step_i};
    assign sum       = wide_code + wide_step;
    assign diff      = wide_code - wide_step;

    always_comb begin
        if (up_i) begin
            res_o = sum[CODE_W] ? CODE_MAX : sum[CODE_W-1:0];
        end else begin
            res_o = diff[CODE_W] ? '0 : diff[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/ssc_search_ctrl.sv
// Decision decode, reversal detection, step halving and lock tracking.
module ssc_search_ctrl
    import ssc_code_pkg::*;
#(
    parameter int STEP_W    = 16,
    parameter int INIT_STEP = 16384,
    parameter int LOCK_RUNS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              early_i,
    input  logic              late_i,
    input  logic              freeze_i,
    output logic              dec_valid_o,
    output logic              dec_up_o,
    output logic              reversal_o,
    output logic [STEP_W-1:0] step_o,
    output logic              locked_o
);
    localparam int CNT_W = $clog2(LOCK_RUNS + 1);
    localparam logic [CNT_W-1:0]  RUNS_FULL = CNT_W'(LOCK_RUNS);
    localparam logic [STEP_W-1:0] STEP_MIN  = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_RST  = STEP_W'(INIT_STEP);

    typedef struct packed {
        pol_e              pol;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  runs;
        logic              locked;
    } srch_t;

    srch_t st_q, st_d;
    pol_e  dec_pol;
    logic  [STEP_W-1:0] half_step;

    always_comb begin
        dec_valid_o = !freeze_i && (early_i ^ late_i);
        dec_up_o    = early_i;
        dec_pol     = early_i ? POL_EARLY : POL_LATE;
        reversal_o  = dec_valid_o && (st_q.pol != POL_NONE) && (st_q.pol != dec_pol);
        half_step   = st_q.step >> 1;

        st_d = st_q;
        if (dec_valid_o) begin
            st_d.pol = dec_pol;
        end
        if (reversal_o) begin
            st_d.step = (half_step == '0) ? STEP_MIN : half_step;
            if (st_q.step == STEP_MIN) begin
                st_d.runs = (st_q.runs == RUNS_FULL) ? st_q.runs : st_q.runs + CNT_W'(1);
            end else begin
                st_d.runs = '0;
            end
        end
        st_d.locked = st_q.locked || (st_d.runs == RUNS_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pol: POL_NONE, step: STEP_RST, runs: '0, locked: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o   = st_q.step;
    assign locked_o = st_q.locked;

    // R5: step stays at least 1 and shrinks at each reversal above the floor
    p_step_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (st_q.step != '0));
    p_step_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reversal_o && st_q.step > STEP_MIN) |=> (st_q.step < $past(st_q.step)));
    // R7: lock is sticky and only appears once the step is at its floor
    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> st_q.locked);
    p_lock_at_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> (st_q.step == STEP_MIN));

endmodule

// File: rtl/ssc_code_ctrl.sv
// Bang-bang loop filter and oscillator code generator with spread mode.
module ssc_code_ctrl #(
    parameter int CODE_W    = 18,
    parameter int STEP_W    = 16,
    parameter int MOD_W     = 16,
    parameter int INIT_STEP = 16384,
    parameter int LOCK_RUNS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              early_i,
    input  logic              late_i,
    input  logic              spread_req_i,
    input  logic              mod_add_i,
    input  logic [MOD_W-1:0]  mod_step_i,
    output logic [CODE_W-1:0] code_o,
    output logic [CODE_W-1:0] base_o,
    output logic              locked_o
);
    localparam logic [CODE_W-1:0] INIT_CODE = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] base;
        logic [CODE_W-1:0] last_rev;
        logic              spread;
    } gen_t;

    gen_t gen_q, gen_d;

    logic              freeze;
    logic              dec_valid;
    logic              dec_up;
    logic              reversal;
    logic              locked;
    logic [STEP_W-1:0] srch_step;
    logic [CODE_W-1:0] trk_code;
    logic [CODE_W-1:0] mod_code;
    logic [CODE_W-1:0] avg_code;

    assign freeze = gen_q.spread || (spread_req_i && locked);

    ssc_search_ctrl #(
        .STEP_W   (STEP_W),
        .INIT_STEP(INIT_STEP),
        .LOCK_RUNS(LOCK_RUNS)
    ) u_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .early_i    (early_i),
        .late_i     (late_i),
        .freeze_i   (freeze),
        .dec_valid_o(dec_valid),
        .dec_up_o   (dec_up),
        .reversal_o (reversal),
        .step_o     (srch_step),
        .locked_o   (locked)
    );

    ssc_sat_adj #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_trk_adj (
        .code_i(gen_q.code),
        .step_i(srch_step),
        .up_i  (dec_up),
        .res_o (trk_code)
    );

    ssc_sat_adj #(.CODE_W(CODE_W), .STEP_W(MOD_W)) u_mod_adj (
        .code_i(gen_q.code),
        .step_i(mod_step_i),
        .up_i  (mod_add_i),
        .res_o (mod_code)
    );

    // Floor of the mean of the two most recent reversal codes.
    assign avg_code = CODE_W'(({1'b0, gen_q.last_rev} + {1'b0, gen_q.code}) >> 1);

    always_comb begin
        gen_d = gen_q;
        if (gen_q.spread) begin
            if (spread_req_i) begin
                gen_d.code = mod_code;
            end else begin
                gen_d.code   = gen_q.base;
                gen_d.spread = 1'b0;
            end
        end else if (spread_req_i && locked) begin
            gen_d.code   = gen_q.base;
            gen_d.spread = 1'b1;
        end else if (reversal) begin
            gen_d.code     = avg_code;
            gen_d.base     = avg_code;
            gen_d.last_rev = gen_q.code;
        end else if (dec_valid) begin
            gen_d.code = trk_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '{code: INIT_CODE, base: INIT_CODE, last_rev: INIT_CODE, spread: 1'b0};
        end else begin
            gen_q <= gen_d;
        end
    end

    assign code_o   = gen_q.code;
    assign base_o   = gen_q.base;
    assign locked_o = locked;

    // R2 / R3: a non-reversing decision moves the code the right way
    p_early_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_up && !reversal) |=> (gen_q.code >= $past(gen_q.code)));
    p_late_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_up && !reversal) |=> (gen_q.code <= $past(gen_q.code)));
    // R4: a reversal leaves code and baseline equal
    p_reload_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reversal |=> (gen_q.code == gen_q.base));
    // R6: no valid decision in tracking leaves the code alone
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && (early_i == late_i)) |=> (gen_q.code == $past(gen_q.code)));
    // R8: the center stays put while spreading
    p_center_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q.spread |=> (gen_q.base == $past(gen_q.base)));
    // R9: no spread mode without lock
    p_no_spread_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !gen_q.spread);
    // R10: leaving spread mode returns to the center
    p_exit_center_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q.spread && !spread_req_i) |=> (!gen_q.spread && gen_q.code == $past(gen_q.base)));

endmodule

// File: tb/tb_ssc_code_ctrl.sv
module tb_ssc_code_ctrl;

    localparam int CMAX   = 262143;
    localparam int TARGET = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        early = 1'b0;
    logic        late = 1'b0;
    logic        req = 1'b0;
    logic        madd = 1'b0;
    logic [15:0] mstep = 16'd0;
    logic [17:0] code;
    logic [17:0] base;
    logic        locked;

    always #4 clk = ~clk;

    ssc_code_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .early_i     (early),
        .late_i      (late),
        .spread_req_i(req),
        .mod_add_i   (madd),
        .mod_step_i  (mstep),
        .code_o      (code),
        .base_o      (base),
        .locked_o    (locked)
    );

    int vectors = 0;
    int miscompares = 0;

    // Behavioural reference state
    int    m_code = 131072;
    int    m_base = 131072;
    int    m_last = 131072;
    int    m_step = 16384;
    int    m_pol  = 0;      // 0 none, 1 early, 2 late
    int    m_runs = 0;
    bit    m_lock = 1'b0;
    bit    m_spr  = 1'b0;
    string tag    = "R1";

    function automatic int clampc(input int v);
        if (v < 0) return 0;
        if (v > CMAX) return CMAX;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 131072; m_base = 131072; m_last = 131072;
            m_step = 16384; m_pol = 0; m_runs = 0; m_lock = 0; m_spr = 0;
            tag = "R1";
        end else if (m_spr) begin
            if (req) begin
                m_code = clampc(madd ? m_code + int'(mstep) : m_code - int'(mstep));
                tag = "R8";
            end else begin
                m_code = m_base; m_spr = 0; tag = "R10";
            end
        end else if (req && m_lock) begin
            m_spr = 1; m_code = m_base; tag = "R8";
        end else begin
            int d;
            d = (early && !late) ? 1 : ((late && !early) ? 2 : 0);
            if (d == 0) begin
                tag = "R6";
            end else if (m_pol != 0 && d != m_pol) begin
                int nb;
                nb = (m_last + m_code) / 2;
                m_last = m_code; m_code = nb; m_base = nb;
                if (m_step == 1) m_runs = (m_runs < 4) ? m_runs + 1 : 4;
                else m_runs = 0;
                m_step = (m_step / 2 < 1) ? 1 : m_step / 2;
                if (m_runs == 4) m_lock = 1;
                m_pol = d;
                tag = "R4,R5,R7";
            end else begin
                m_code = clampc(d == 1 ? m_code + m_step : m_code - m_step);
                m_pol = d;
                tag = (d == 1) ? "R2" : "R3";
            end
            if (req) tag = {tag, ",R9"};
        end
    end

    always @(negedge clk) begin
        vectors++;
        if (int'(code) != m_code) begin
            miscompares++;
            $display("FAIL %s code_o actual=%0d expected=%0d", tag, code, m_code);
        end
        if (int'(base) != m_base) begin
            miscompares++;
            $display("FAIL %s base_o actual=%0d expected=%0d", tag, base, m_base);
        end
        if (locked != m_lock) begin
            miscompares++;
            $display("FAIL R7 locked_o actual=%0d expected=%0d", locked, m_lock);
        end
    end

    task automatic apply(input bit e, input bit l, input bit r, input bit a, input int s);
        @(negedge clk);
        early = e; late = l; req = r; madd = a; mstep = 16'(s);
    endtask

    task automatic track(input int n, input bit r);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            early = (int'(code) <= TARGET);
            late  = !(int'(code) <= TARGET);
            req   = r;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1: reset state observed for a few cycles
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: neither and both asserted
        for (int i = 0; i < 3; i++) apply(0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) apply(1, 1, 0, 0, 0);
        // R2: early run up into the top saturation
        for (int i = 0; i < 10; i++) apply(1, 0, 0, 0, 0);
        // R4/R5 then R3: reversal, then late run down into zero
        for (int i = 0; i < 30; i++) apply(0, 1, 0, 0, 0);
        // R9: spread request before lock is ignored
        for (int i = 0; i < 4; i++) apply(0, 0, 1, 1, 500);
        for (int i = 0; i < 2; i++) apply(1, 0, 1, 1, 500);
        // R7: closed loop until lock
        for (int i = 0; i < 3000 && !locked; i++) track(1, 0);
        track(12, 0);
        // R8: triangular sweep with detector activity ignored
        for (int i = 0; i < 20; i++) apply(i[0], !i[0], 1, 1, 37);
        for (int i = 0; i < 20; i++) apply(!i[0], i[0], 1, 0, 37);
        // R8: saturation at both ends
        for (int i = 0; i < 5; i++) apply(1, 0, 1, 1, 65535);
        for (int i = 0; i < 8; i++) apply(0, 1, 1, 0, 65535);
        // R10: exit back to center, then tracking resumes
        apply(1, 0, 0, 1, 0);
        track(30, 0);
        // R8/R10: re-entry with the sticky lock, then exit
        for (int i = 0; i < 10; i++) apply(0, 0, 1, i < 5, 1000);
        apply(0, 1, 0, 0, 0);
        track(5, 0);
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule